// File: doc/BRIEF.md
# Tagged Pointer Equality Comparator

This block settles the equality of two tagged capability pointers for a pointer-equal or pointer-not-equal instruction. When objects can be moved and left behind with forwarding words, two different addresses may still name the same object. A plain bitwise compare is therefore unsafe. The block gives a fast answer only where one can be proven from the pointer bits alone. In every other case it asks for a trap, and a software handler then follows the forwarding chains.

Each pointer holds an address and a capability word. The capability word carries a segment-length field and a short random object tag. The segment length splits the address into an object base and an offset within the object. The verdict is built from three tests: whether the two addresses match, whether the tags differ, and whether the two pointers share a base. An operand whose type bit marks it as plain data is refused with a type fault. The verdict appears one clock after the request strobe.

Top module: `ptr_eq_cmp`

## Requirements
- R1: A pointer is ADDR_W+CAP_W bits wide. The address is bits [ADDR_W-1:0] and the capability word is the bits above it. Within the capability word, bits [5:0] are the segment length and bits [6+TAG_W-1:6] are the object tag. All other capability bits, including tag-region bits [13:6+TAG_W], do not affect the verdict.
- R2: If either type input is 0 (plain data), the block pulses `out_fault` alone, whatever the pointer values are.
- R3: Two pointers with identical addresses compare as equal, whatever their capability words hold.
- R4: Two pointers with different addresses and different object tags compare as not-equal, with no trap.
- R5: Two pointers with different addresses, equal tags, equal segment lengths and equal bases (address shifted right by the segment length) compare as not-equal, with no trap.
- R6: Two pointers with different addresses that neither R4 nor R5 resolves raise `out_trap` and no result.
- R7: `op_ne`=0 asks for equality and `op_ne`=1 asks for inequality. `out_result` is 1 exactly when the asked relation holds, so the two opcodes give inverse results.
- R8: Exactly one of `out_done`, `out_trap` and `out_fault` pulses in the cycle after a cycle with `in_valid` high. None of them pulses after a cycle with `in_valid` low. `out_result` is 0 whenever `out_done` is 0.
- R9: With TAG_W=0 the tag test never resolves a compare. Different addresses then give not-equal only through R5 and trap otherwise.
- R10: While `rst` is high, all outputs are 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| op_ne | input | 1 | 0 asks for equality, 1 asks for inequality |
| ptr_a | input | ADDR_W+CAP_W | First operand |
| ptr_b | input | ADDR_W+CAP_W | Second operand |
| is_ptr_a | input | 1 | 1 when ptr_a holds a pointer, 0 when it holds data |
| is_ptr_b | input | 1 | 1 when ptr_b holds a pointer, 0 when it holds data |
| out_done | output | 1 | Result valid pulse |
| out_result | output | 1 | Truth of the asked relation, valid with out_done |
| out_trap | output | 1 | Request for the software forwarding walk |
| out_fault | output | 1 | Type fault: an operand is plain data |

## Verification
The assertions assume that `rst` is held high long enough to clear the output flops before the first request. They also assume that the operand and opcode inputs are settled in any cycle where `in_valid` is high, since `$past` of those inputs forms each expected value. The bench meets both conditions. It drives every input on the falling clock edge, keeps `in_valid` low throughout reset, and only then sweeps small address, length and tag ranges back to back. These sweeps deliberately put differing values into the capability bits that the verdict ignores.

// File: rtl/ptrcmp_pkg.sv
package ptrcmp_pkg;
  localparam int SEGLEN_W     = 6;
  localparam int SEGLEN_LSB   = 0;
  localparam int TAG_FIELD_LSB = 6;
  localparam int TAG_FIELD_W  = 8;
  localparam int CAP_USED_W   = TAG_FIELD_LSB + TAG_FIELD_W;

  typedef enum logic [1:0] {
    VERD_EQ    = 2'd0,
    VERD_NE    = 2'd1,
    VERD_TRAP  = 2'd2,
    VERD_FAULT = 2'd3
  } verdict_e;
endpackage

// File: rtl/ptrcmp_fields.sv
module ptrcmp_fields
  import ptrcmp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CAP_W  = 64,
  parameter int TAG_W  = 8
) (
  input  logic [ADDR_W+CAP_W-1:0] ptr,
  output logic [ADDR_W-1:0]       addr,
  output logic [SEGLEN_W-1:0]     seglen,
  output logic [TAG_FIELD_W-1:0]  tag,
  output logic [ADDR_W-1:0]       base
);
  localparam logic [TAG_FIELD_W-1:0] TAG_MASK =
    (TAG_W == 0) ? '0 : TAG_FIELD_W'((9'd1 << TAG_W) - 9'd1);

  logic [CAP_W-1:0] cap;
  logic             unused_perm_bits;

  assign addr   = ptr[ADDR_W-1:0];
  assign cap    = ptr[ADDR_W+CAP_W-1:ADDR_W];
  assign seglen = cap[SEGLEN_LSB +: SEGLEN_W];
  assign tag    = cap[TAG_FIELD_LSB +: TAG_FIELD_W] & TAG_MASK;
  assign base   = addr >> seglen;

  generate
    if (CAP_W > CAP_USED_W) begin : g_spare
      assign unused_perm_bits = ^cap[CAP_W-1:CAP_USED_W];
    end else begin : g_nospare
      assign unused_perm_bits = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ptrcmp_decide.sv
module ptrcmp_decide
  import ptrcmp_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic                   is_ptr_a,
  input  logic                   is_ptr_b,
  input  logic [ADDR_W-1:0]      addr_a,
  input  logic [ADDR_W-1:0]      addr_b,
  input  logic [SEGLEN_W-1:0]    len_a,
  input  logic [SEGLEN_W-1:0]    len_b,
  input  logic [TAG_FIELD_W-1:0] tag_a,
  input  logic [TAG_FIELD_W-1:0] tag_b,
  input  logic [ADDR_W-1:0]      base_a,
  input  logic [ADDR_W-1:0]      base_b,
  output verdict_e               verdict
);
  logic same_addr, tag_split, same_object;

  assign same_addr   = (addr_a == addr_b);
  assign tag_split   = (tag_a != tag_b);
  assign same_object = (len_a == len_b) && (base_a == base_b);

  always_comb begin
    if (!(is_ptr_a && is_ptr_b))  verdict = VERD_FAULT;
    else if (same_addr)           verdict = VERD_EQ;
    else if (tag_split)           verdict = VERD_NE;
    else if (same_object)         verdict = VERD_NE;
    else                          verdict = VERD_TRAP;
  end
endmodule

// File: rtl/ptr_eq_cmp.sv
module ptr_eq_cmp
  import ptrcmp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CAP_W  = 64,
  parameter int TAG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    op_ne,
  input  logic [ADDR_W+CAP_W-1:0] ptr_a,
  input  logic [ADDR_W+CAP_W-1:0] ptr_b,
  input  logic                    is_ptr_a,
  input  logic                    is_ptr_b,
  output logic                    out_done,
  output logic                    out_result,
  output logic                    out_trap,
  output logic                    out_fault
);
  localparam int PTR_W = ADDR_W + CAP_W;
  localparam int NOPS  = 2;

  logic [PTR_W-1:0]       ptr_v    [NOPS];
  logic [ADDR_W-1:0]      addr_v   [NOPS];
  logic [SEGLEN_W-1:0]    len_v    [NOPS];
  logic [TAG_FIELD_W-1:0] tag_v    [NOPS];
  logic [ADDR_W-1:0]      base_v   [NOPS];
  verdict_e               verdict;

  assign ptr_v[0] = ptr_a;
  assign ptr_v[1] = ptr_b;

  generate
    for (genvar i = 0; i < NOPS; i++) begin : g_opnd
      ptrcmp_fields #(.ADDR_W(ADDR_W), .CAP_W(CAP_W), .TAG_W(TAG_W)) u_fields (
        .ptr    (ptr_v[i]),
        .addr   (addr_v[i]),
        .seglen (len_v[i]),
        .tag    (tag_v[i]),
        .base   (base_v[i])
      );
    end
  endgenerate

  ptrcmp_decide #(.ADDR_W(ADDR_W)) u_decide (
    .is_ptr_a (is_ptr_a),
    .is_ptr_b (is_ptr_b),
    .addr_a   (addr_v[0]),
    .addr_b   (addr_v[1]),
    .len_a    (len_v[0]),
    .len_b    (len_v[1]),
    .tag_a    (tag_v[0]),
    .tag_b    (tag_v[1]),
    .base_a   (base_v[0]),
    .base_b   (base_v[1]),
    .verdict  (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done   <= 1'b0;
      out_result <= 1'b0;
      out_trap   <= 1'b0;
      out_fault  <= 1'b0;
    end else begin
      out_done   <= in_valid && (verdict == VERD_EQ || verdict == VERD_NE);
      out_result <= in_valid && (verdict == VERD_EQ || verdict == VERD_NE)
                    && ((verdict == VERD_EQ) ^ op_ne);
      out_trap   <= in_valid && (verdict == VERD_TRAP);
      out_fault  <= in_valid && (verdict == VERD_FAULT);
    end
  end
endmodule

// File: rtl/ptr_eq_cmp_chk.sv
module ptr_eq_cmp_chk
  import ptrcmp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CAP_W  = 64,
  parameter int TAG_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    op_ne,
  input logic [ADDR_W+CAP_W-1:0] ptr_a,
  input logic [ADDR_W+CAP_W-1:0] ptr_b,
  input logic                    is_ptr_a,
  input logic                    is_ptr_b,
  input logic                    out_done,
  input logic                    out_result,
  input logic                    out_trap,
  input logic                    out_fault
);
  localparam int TAG_LO = ADDR_W + TAG_FIELD_LSB;
  localparam int TW     = (TAG_W == 0) ? 1 : TAG_W;

  logic both_ptr, addr_match, tags_differ;
  assign both_ptr   = is_ptr_a && is_ptr_b;
  assign addr_match = (ptr_a[ADDR_W-1:0] == ptr_b[ADDR_W-1:0]);
  assign tags_differ = (TAG_W != 0) &&
                       (ptr_a[TAG_LO +: TW] != ptr_b[TAG_LO +: TW]);

  // R8
  onehot_resp_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_done, out_trap, out_fault}));

  // R8
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_done || out_trap || out_fault));

  // R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(out_done || out_trap || out_fault || out_result));

  // R2
  type_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !both_ptr) |=> out_fault);

  // R3
  same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && both_ptr && addr_match) |=> (out_done && (out_result == !$past(op_ne))));

  // R4
  tag_split_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && both_ptr && !addr_match && tags_differ)
      |=> (out_done && (out_result == $past(op_ne))));
endmodule

bind ptr_eq_cmp ptr_eq_cmp_chk #(.ADDR_W(ADDR_W), .CAP_W(CAP_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_ne(op_ne),
  .ptr_a(ptr_a), .ptr_b(ptr_b), .is_ptr_a(is_ptr_a), .is_ptr_b(is_ptr_b),
  .out_done(out_done), .out_result(out_result), .out_trap(out_trap), .out_fault(out_fault)
);

// File: tb/sim_ptr_eq_cmp.sv
module sim_ptr_eq_cmp;
  localparam int AW = 8;
  localparam int CW = 16;
  localparam int PW = AW + CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic op_ne = 1'b0;
  logic [PW-1:0] ptr_a = '0, ptr_b = '0;
  logic is_ptr_a = 1'b1, is_ptr_b = 1'b1;
  logic d0, r0, t0, f0, d1, r1, t1, f1;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ptr_eq_cmp #(.ADDR_W(AW), .CAP_W(CW), .TAG_W(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_ne(op_ne),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .is_ptr_a(is_ptr_a), .is_ptr_b(is_ptr_b),
    .out_done(d0), .out_result(r0), .out_trap(t0), .out_fault(f0));

  // R9: tagless variant
  ptr_eq_cmp #(.ADDR_W(AW), .CAP_W(CW), .TAG_W(0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_ne(op_ne),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .is_ptr_a(is_ptr_a), .is_ptr_b(is_ptr_b),
    .out_done(d1), .out_result(r1), .out_trap(t1), .out_fault(f1));

  logic [3:0] exp0, exp1;
  string rq0, rq1;
  logic pending = 1'b0;

  // expected {fault,trap,done,result}
  task automatic model(input logic pa, input logic pb, input logic op,
                       input logic [7:0] aa, input logic [7:0] ab,
                       input logic [5:0] la, input logic [5:0] lb,
                       input logic [7:0] ta, input logic [7:0] tb,
                       input int tagw, output logic [3:0] e, output string rq);
    logic [7:0] m;
    m = (tagw == 0) ? 8'd0 : 8'((9'd1 << tagw) - 9'd1);
    if (!(pa && pb))                          begin e = 4'b1000; rq = "R2"; end
    else if (aa == ab)                        begin e = {3'b001, !op}; rq = "R3/R7"; end
    else if (((ta ^ tb) & m) != 0)            begin e = {3'b001, op}; rq = "R4/R7"; end
    else if (la == lb && (aa >> la) == (ab >> lb)) begin e = {3'b001, op}; rq = "R5/R7"; end
    else                                      begin e = 4'b0100; rq = (tagw == 0) ? "R9/R6" : "R6"; end
  endtask

  task automatic check_one(input string nm, input logic [3:0] act, input logic [3:0] e, input string rq);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s %s: got {fault,trap,done,res}=%b expected %b", rq, nm, act, e);
    end
  endtask

  task automatic check_prev();
    if (pending) begin
      check_one("u0", {f0, t0, d0, r0}, exp0, rq0);
      check_one("u1", {f1, t1, d1, r1}, exp1, rq1);
    end
  endtask

  // R1: layout {perm, tag8, len6, addr}
  task automatic issue(input logic pa, input logic pb, input logic op,
                       input logic [7:0] aa, input logic [7:0] ab,
                       input logic [5:0] la, input logic [5:0] lb,
                       input logic [7:0] ta, input logic [7:0] tb,
                       input logic [1:0] perm_a, input logic [1:0] perm_b);
    @(negedge clk);
    check_prev();
    in_valid = 1'b1; op_ne = op; is_ptr_a = pa; is_ptr_b = pb;
    ptr_a = {perm_a, ta, la, aa};
    ptr_b = {perm_b, tb, lb, ab};
    model(pa, pb, op, aa, ab, la, lb, ta, tb, 2, exp0, rq0);
    model(pa, pb, op, aa, ab, la, lb, ta, tb, 0, exp1, rq1);
    pending = 1'b1;
  endtask

  task automatic go_idle();
    @(negedge clk);
    check_prev();
    in_valid = 1'b0; pending = 1'b0;
    @(negedge clk);
    check_one("u0 idle", {f0, t0, d0, r0}, 4'b0000, "R8");
    check_one("u1 idle", {f1, t1, d1, r1}, 4'b0000, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_one("u0 reset", {f0, t0, d0, r0}, 4'b0000, "R10");
    check_one("u1 reset", {f1, t1, d1, r1}, 4'b0000, "R10");
    rst = 1'b0;
    @(negedge clk);
    check_one("u0 post-reset idle", {f0, t0, d0, r0}, 4'b0000, "R8");

    // Main sweep: addresses, lengths, tags; upper tag and perm bits vary (R1)
    for (int aa = 0; aa < 8; aa++)
      for (int ab = 0; ab < 8; ab++)
        for (int la = 0; la < 4; la++)
          for (int lb = 0; lb < 4; lb++)
            for (int ta = 0; ta < 4; ta++)
              for (int tb = 0; tb < 4; tb++)
                issue(1'b1, 1'b1, 1'((aa ^ ab ^ la ^ tb) & 1),
                      8'(aa), 8'(ab), 6'(la), 6'(lb),
                      {6'(aa * 5 + tb), 2'(ta)}, {6'(ab * 3 + lb), 2'(tb)},
                      2'(aa + la), 2'(ab ^ ta));

    // Wide segment lengths and high addresses
    for (int k = 0; k < 64; k++)
      issue(1'b1, 1'b1, 1'(k & 1), 8'(k * 37), 8'(k * 37 + (k & 3) + 1),
            6'(k), 6'(k), 8'(k & 12), 8'(k & 12), 2'b00, 2'b11);
    go_idle();

    // Type faults (R2), including equal addresses and split tags
    for (int pa = 0; pa < 2; pa++)
      for (int pb = 0; pb < 2; pb++)
        for (int k = 0; k < 4; k++)
          issue(1'(pa), 1'(pb), 1'(k & 1), 8'(k), 8'(k & 2), 6'(k), 6'd1,
                8'(k), 8'd1, 2'b01, 2'b10);
    go_idle();

    // Isolated single requests between idle gaps (R8)
    issue(1'b1, 1'b1, 1'b0, 8'h40, 8'h40, 6'd3, 6'd5, 8'h01, 8'h02, 2'b00, 2'b00);
    go_idle();
    issue(1'b1, 1'b1, 1'b1, 8'h41, 8'h42, 6'd0, 6'd0, 8'h03, 8'h03, 2'b00, 2'b00);
    go_idle();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule